// File: doc/BRIEF.md
# Selectable Clock Divider with Gated Eight-Lane Fanout

This block takes one reference clock, divides it by a power of two and copies the result onto eight output lanes. A two-bit ratio select picks divide-by-1, 2, 4 or 8. The select is driven from pins with no timing relation to the reference clock. Each lane has a disable bit that comes from a control register held elsewhere, such as a serial configuration interface. When the bit is set, the lane's output-enable flag drops and its clock is held low, which stands for a high-impedance driver.

Both control inputs pass through a two-flop synchronizer in the reference domain. A new ratio is committed only at the end of the current output period, while the divided clock is low. Lane enables and the bypass path switch on the falling edge of the reference clock, and only while the output they gate is low. No lane therefore ever shows a pulse shorter than half a reference period. For ratios of 2 and above the output has a 50% duty cycle. Divide-by-1 routes the reference clock straight to the lanes.

Top module: `clkdiv_fanout`

## Requirements
- R1: The ratio select code `ratio_sel` sets the output frequency as f_ref / 2^code: 00 gives divide-by-1, 01 divide-by-2, 10 divide-by-4 and 11 divide-by-8.
- R2: Every enabled lane is high for exactly half of each output period, for all four ratios.
- R3: All enabled lanes carry the same waveform at every instant.
- R4: A lane whose bit in `lane_off` is 0 has `lane_oe` = 1 and toggles. A lane whose bit is 1 has `lane_oe` = 0 and `lane_clk` held at 0. Bit n controls lane n.
- R5: While `rst` is high and after its release, the following hold until the synchronized disable bits (reset value all ones) are cleared: all lanes are disabled, the divider counter is zero and divide-by-1 is selected.
- R6: No high or low pulse on a lane is shorter than half a reference period, including while the ratio or the enables change.
- R7: A new select value reaches the divider through two synchronizer flops. From divide-by-1, a change driven just after rising edge 0 is committed at rising edge 3, and the new divided waveform starts high at edge 4. From any ratio, a change takes effect within 12 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | SEL_W (2) | Asynchronous ratio select, code c divides by 2^c |
| lane_off | input | LANES (8) | Asynchronous per-lane disable, 1 = disabled |
| lane_clk | output | LANES (8) | Divided clock per lane, held 0 when disabled |
| lane_oe | output | LANES (8) | Per-lane output enable, 0 models high impedance |

## Verification
On every rising edge, the assertions check the following: the divider count stays inside the current ratio; a ratio is committed only while the divided clock is low; the committed code equals the select sampled three edges earlier; a new period starts from count zero; a lane without enable is low; and the reset state is right. Only the bench scenarios can show the frequency per ratio, the 50% duty and the lane-to-lane match, because these need whole output periods sampled at both clock phases. The same holds for the absence of runt pulses under fast switching, measured in time on a lane, and for the exact commit edge after a select change.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Division ratio for a select code: 2 to the power of the code.
  function automatic int unsigned ratio_of(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Code zero routes the reference clock straight through.
  function automatic logic code_is_bypass(input int unsigned code);
    return code == 0;
  endfunction

endpackage

// File: rtl/cdf_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bus of independent asynchronous bits.
module cdf_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cdf_divider.sv
`timescale 1ns/1ps
// Power-of-two divider; ratio changes are committed only at a period end.
module cdf_divider
  import clkdiv_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_s,
  output logic [SEL_W-1:0] code_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             div_q,
  output logic             bypass_q
);
  int unsigned      n_cur, n_new;
  logic [CNT_W-1:0] last_cur, last_new, cnt_inc;
  logic [CNT_W:0]   half_cur;
  logic             boundary, next_high, change;

  always_comb begin
    n_cur     = ratio_of(32'(code_q));
    n_new     = ratio_of(32'(sel_s));
    last_cur  = CNT_W'(n_cur - 1);
    last_new  = CNT_W'(n_new - 1);
    half_cur  = (CNT_W+1)'(n_cur >> 1);
    cnt_inc   = cnt_q + 1'b1;
    boundary  = (cnt_q == last_cur);
    next_high = ({1'b0, cnt_inc} < half_cur);
    change    = boundary && (sel_s != code_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      cnt_q    <= '0;
      div_q    <= 1'b0;
      bypass_q <= 1'b1;
    end else if (change) begin
      code_q   <= sel_s;
      bypass_q <= code_is_bypass(32'(sel_s));
      if (code_is_bypass(32'(sel_s))) begin
        cnt_q <= '0;
        div_q <= 1'b0;
      end else if (bypass_q) begin
        // leaving bypass: hold low for one cycle, period starts next edge
        cnt_q <= last_new;
        div_q <= 1'b0;
      end else begin
        cnt_q <= '0;
        div_q <= 1'b1;
      end
    end else if (bypass_q) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (boundary) begin
      cnt_q <= '0;
      div_q <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      div_q <= next_high;
    end
  end
endmodule

// File: rtl/cdf_lane_gate.sv
`timescale 1ns/1ps
// Falling-edge gating of the bypass path and per-lane enables.
module cdf_lane_gate #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass_q,
  input  logic             div_q,
  input  logic [LANES-1:0] off_s,
  output logic [LANES-1:0] lane_clk,
  output logic [LANES-1:0] lane_oe
);
  logic             bypass_n;
  logic [LANES-1:0] en_n;
  logic             out_low_safe;
  logic             gclk;

  // At a falling edge the bypass path goes low; the divided path is safe
  // to gate only while it is low.
  assign out_low_safe = bypass_n | ~div_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      bypass_n <= 1'b1;
      en_n     <= '0;
    end else begin
      bypass_n <= bypass_q;
      if (out_low_safe) en_n <= ~off_s;
    end
  end

  assign gclk = bypass_n ? clk : div_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_clk[i] = en_n[i] & gclk;
    assign lane_oe[i]  = en_n[i];
  end
endmodule

// File: rtl/clkdiv_fanout.sv
`timescale 1ns/1ps
// Selectable power-of-two clock divider with gated multi-lane fanout.
module clkdiv_fanout #(
  parameter int LANES = 8,
  parameter int SEL_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic [LANES-1:0] lane_off,
  output logic [LANES-1:0] lane_clk,
  output logic [LANES-1:0] lane_oe
);
  localparam int MAX_SHIFT = (1 << SEL_W) - 1;
  localparam int CNT_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [SEL_W-1:0] sel_s;
  logic [LANES-1:0] off_s;
  logic [SEL_W-1:0] code_q;
  logic [CNT_W-1:0] cnt_q;
  logic             div_q;
  logic             bypass_q;

  cdf_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sel_sync (
    .clk(clk_ref), .rst(rst), .d(ratio_sel), .q(sel_s)
  );

  cdf_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES), .RST_VAL({LANES{1'b1}})) u_off_sync (
    .clk(clk_ref), .rst(rst), .d(lane_off), .q(off_s)
  );

  cdf_divider #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
    .clk(clk_ref), .rst(rst), .sel_s(sel_s),
    .code_q(code_q), .cnt_q(cnt_q), .div_q(div_q), .bypass_q(bypass_q)
  );

  cdf_lane_gate #(.LANES(LANES)) u_gate (
    .clk(clk_ref), .rst(rst), .bypass_q(bypass_q), .div_q(div_q),
    .off_s(off_s), .lane_clk(lane_clk), .lane_oe(lane_oe)
  );
endmodule

// File: rtl/clkdiv_fanout_chk.sv
`timescale 1ns/1ps
module clkdiv_fanout_chk #(
  parameter int LANES = 8,
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input logic             clk_ref,
  input logic             rst,
  input logic [SEL_W-1:0] ratio_sel,
  input logic [SEL_W-1:0] code_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             div_q,
  input logic [LANES-1:0] lane_clk,
  input logic [LANES-1:0] lane_oe
);
  p_cnt_bound_r1: assert property (@(posedge clk_ref) disable iff (rst)
    32'(cnt_q) < (32'd1 << code_q));

  p_period_start_r2: assert property (@(posedge clk_ref) disable iff (rst)
    ($rose(div_q) && $stable(code_q)) |-> (cnt_q == '0));

  p_off_lane_low_r4: assert property (@(posedge clk_ref) disable iff (rst)
    (lane_clk & ~lane_oe) == '0);

  p_reset_state_r5: assert property (@(posedge clk_ref) disable iff (rst)
    $past(rst) |-> (lane_oe == '0 && cnt_q == '0 && code_q == '0));

  p_commit_low_r6: assert property (@(posedge clk_ref) disable iff (rst)
    !$stable(code_q) |-> !$past(div_q));

  p_sync_delay_r7: assert property (@(posedge clk_ref) disable iff (rst)
    (!$stable(code_q) && !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
      |-> (code_q == $past(ratio_sel, 3)));
endmodule

bind clkdiv_fanout clkdiv_fanout_chk #(.LANES(LANES), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk_ref(clk_ref), .rst(rst), .ratio_sel(ratio_sel), .code_q(code_q),
  .cnt_q(cnt_q), .div_q(div_q), .lane_clk(lane_clk), .lane_oe(lane_oe)
);

// File: tb/clkdiv_fanout_bench.sv
`timescale 1ns/1ps
module clkdiv_fanout_bench;
  logic       clk_ref = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ratio_sel = 2'd0;
  logic [7:0] lane_off = 8'hFF;
  logic [7:0] lane_clk, lane_oe;

  int n_vec = 0;
  int n_bad = 0;
  int runts = 0;
  bit mon_on = 1'b0;
  realtime t_last = -1.0;

  clkdiv_fanout u_clkdiv_fanout (
    .clk_ref(clk_ref), .rst(rst), .ratio_sel(ratio_sel),
    .lane_off(lane_off), .lane_clk(lane_clk), .lane_oe(lane_oe)
  );

  always #2.5 clk_ref = ~clk_ref;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  // R6: pulse width on lane 0 measured in time
  always @(lane_clk[0]) begin
    if (mon_on) begin
      if (t_last >= 0.0 && ($realtime - t_last) < 2.4) runts++;
      t_last = $realtime;
    end
  end

  task automatic measure(input logic [1:0] sel, input logic [7:0] off, input int settle);
    logic [7:0] smp [0:128];
    logic [7:0] oe_seen;
    int mism;
    @(posedge clk_ref); #1;
    ratio_sel = sel;
    lane_off  = off;
    repeat (settle) @(posedge clk_ref);
    @(negedge clk_ref); #1;
    smp[0] = lane_clk;
    for (int c = 0; c < 64; c++) begin
      @(posedge clk_ref); #1; smp[2*c+1] = lane_clk;
      @(negedge clk_ref); #1; smp[2*c+2] = lane_clk;
    end
    oe_seen = lane_oe;
    for (int l = 0; l < 8; l++) begin
      int highs, rises, exp_h, exp_r;
      highs = 0; rises = 0;
      for (int k = 1; k <= 128; k++) begin
        if (smp[k][l]) highs++;
        if (smp[k][l] && !smp[k-1][l]) rises++;
      end
      exp_h = off[l] ? 0 : 64;
      exp_r = off[l] ? 0 : (64 >> sel);
      check(oe_seen[l] == !off[l], "R4", $sformatf("oe lane%0d sel%0d off%02h", l, sel, off),
            int'(oe_seen[l]), int'(!off[l]));
      check(rises == exp_r, "R1", $sformatf("rises lane%0d sel%0d off%02h", l, sel, off),
            rises, exp_r);
      check(highs == exp_h, "R2", $sformatf("high halves lane%0d sel%0d off%02h", l, sel, off),
            highs, exp_h);
    end
    mism = 0;
    for (int k = 1; k <= 128; k++) begin
      logic [7:0] ref_v;
      ref_v = (|smp[k]) ? ~off : 8'h00;
      if (smp[k] != ref_v) mism++;
    end
    check(mism == 0, "R3", $sformatf("lane match sel%0d off%02h", sel, off), mism, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [0:9];
    logic e1, e2;
    // R5: reset state
    repeat (6) @(posedge clk_ref);
    #1;
    check(lane_oe == 8'h00, "R5", "oe in reset", int'(lane_oe), 0);
    check(lane_clk == 8'h00, "R5", "clk in reset", int'(lane_clk), 0);
    rst = 1'b0;
    repeat (10) @(posedge clk_ref);
    #1;
    check(lane_oe == 8'h00, "R5", "oe after reset, defaults", int'(lane_oe), 0);
    @(negedge clk_ref); #1;
    check(lane_clk == 8'h00, "R5", "clk after reset, defaults", int'(lane_clk), 0);
    mon_on = 1'b1;

    // R1 R2 R3 R4: sweep of ratios and enable patterns
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hAA; pats[3] = 8'h55;
    pats[4] = 8'h0F; pats[5] = 8'hF0; pats[6] = 8'hFE; pats[7] = 8'h7F;
    pats[8] = 8'h3C; pats[9] = 8'h81;
    for (int p = 0; p < 10; p++) begin
      for (int s = 0; s < 4; s++) begin
        measure(2'((s * 3 + p) % 4), pats[p], 16);
      end
    end

    // R7: exact commit edge from divide-by-1 to divide-by-8
    measure(2'd0, 8'h00, 16);
    @(posedge clk_ref); #1;
    ratio_sel = 2'd3;
    for (int e = 1; e <= 11; e++) begin
      @(posedge clk_ref); #1; e1 = lane_clk[0];
      @(negedge clk_ref); #1; e2 = lane_clk[0];
      check(e1 == (e <= 7), "R7", $sformatf("rise-phase edge %0d", e), int'(e1), int'(e <= 7));
      check(e2 == (e >= 4 && e <= 7), "R7", $sformatf("fall-phase edge %0d", e),
            int'(e2), int'(e >= 4 && e <= 7));
    end
    // R7: change from divide-by-8 to divide-by-1 settles within 12 cycles
    measure(2'd0, 8'h00, 12);
    measure(2'd3, 8'h00, 12);
    measure(2'd1, 8'h00, 12);

    // R6: fast switching of ratio and lane 0 enable
    for (int it = 0; it < 600; it++) begin
      @(posedge clk_ref); #1;
      if (it % 3 == 0) ratio_sel = 2'((it * 7 + it / 5) % 4);
      if (it % 11 == 0) lane_off = {7'h00, 1'((it / 11) % 3 == 2)};
    end
    measure(2'd2, 8'h00, 16);
    check(runts == 0, "R6", "short pulses on lane 0", runts, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule